// File: doc/BRIEF.md
# Banked Indexed Register Window for a Real-Time-Clock Block

This block gives a host a two-location window into a 128-entry real-time-clock register space. The host first writes a location number into the pointer port (bus offset 0). It then reads or writes that location through the data port (bus offset 1). The lower 64 locations are common to every bank. Among them are four control bytes at 0Ah, 0Bh, 0Ch and 0Dh. What the upper 64 locations reach depends on a three-bit page field held in bits 6:4 of the control byte at 0Ah.

Page 0 and page 2 each expose their own 64 bytes of plain storage. Page 1 exposes a second level of addressing. Location 50h holds a 7-bit pointer into a separate 128-byte extended RAM, and location 53h reads or writes the extended RAM byte that the pointer selects. Any other page value, and any other page-1 location, reads as zero.

Bit 7 of the byte at 0Dh reflects a validity input. While that input is low, every data-port write is dropped. The control byte at 0Ah is further protected: it accepts writes only after the host has read location 0Dh through the data port at least once since reset.

Top module: `rtc_bank_window`

## Requirements
- R1: A write at bus offset 0 loads the pointer with bits 6:0 of the write data. A read at offset 0 returns the pointer with bit 7 as 0. Data-port accesses never change the pointer: there is no auto-increment.
- R2: A data-port access at locations 00h to 3Fh reaches the same byte whatever the page. All 8 bits of each byte are stored and read back, reserved bits included.
- R3: Bits 6:4 of location 0Ah select the page. With page 0 the locations 40h to 7Fh reach one 64-byte store, and with page 2 they reach a second, separate 64-byte store.
- R4: With page 1, location 50h is a 7-bit extended-RAM pointer that reads back with bit 7 as 0. Location 53h reads or writes the extended-RAM byte at that pointer. Accesses to 53h leave the extended-RAM pointer unchanged.
- R5: With page 1, upper locations other than 50h and 53h read 00h and ignore writes. With page values 3 to 7, every upper location reads 00h and ignores writes.
- R6: Reading location 0Dh returns the ram_valid input in bit 7 and the stored bits 6:0. Bit 7 of a write to 0Dh has no effect.
- R7: Every data-port write is ignored while ram_valid is low. Pointer-port writes still take effect.
- R8: A write to location 0Ah is ignored until a data-port read of location 0Dh has occurred since reset. Once set, this permission stays set until reset.
- R9: Reset clears the pointer, all stores, the control bytes, the extended-RAM pointer and the read permission. host_rdata is 00h whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_sel | input | 1 | Host access select |
| host_port | input | 1 | 0 = pointer port, 1 = data port |
| host_rd | input | 1 | Read request |
| host_wr | input | 1 | Write request |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data; combinational, 00h when not reading |
| ram_valid | input | 1 | Validity flag; low blocks data writes and appears as bit 7 of 0Dh |

## Verification
Some properties are checked by assertions on every cycle. These cover four behaviours:
- the pointer holding its value when no pointer write occurs;
- the control byte at 0Ah staying frozen before the 0Dh read;
- the read permission never clearing once set;
- writes with ram_valid low leaving the control bytes and the extended-RAM pointer untouched.

The assertions also check that a quiet bus reads zero and that the extended-RAM pointer reads with bit 7 clear. Other behaviour can only be shown by the bench's scenarios:
- that the page-0 and page-2 stores and the extended RAM are truly separate;
- that bytes written under one page survive a page change;
- that unmapped locations read zero;
- that accesses to 53h leave the extended-RAM pointer unchanged.

The bench's pseudo-random sweep compares these against its own model.

// File: rtl/rtc_win_pkg.sv
package rtc_win_pkg;
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_LOW,
    TGT_CTLA,
    TGT_CTLD,
    TGT_PAGE0,
    TGT_PAGE2,
    TGT_XPTR,
    TGT_XDAT
  } tgt_e;

  localparam logic [6:0] IDX_CTLA = 7'h0A;
  localparam logic [6:0] IDX_CTLD = 7'h0D;
  localparam logic [6:0] IDX_XPTR = 7'h50;
  localparam logic [6:0] IDX_XDAT = 7'h53;

  localparam logic [2:0] PAGE_0 = 3'd0;
  localparam logic [2:0] PAGE_1 = 3'd1;
  localparam logic [2:0] PAGE_2 = 3'd2;
endpackage

// File: rtl/rtc_win_decode.sv
module rtc_win_decode
  import rtc_win_pkg::*;
(
  input  logic [6:0] idx,
  input  logic [2:0] page,
  output tgt_e       tgt
);
  always_comb begin
    tgt = TGT_NONE;
    if (!idx[6]) begin
      if (idx == IDX_CTLA)      tgt = TGT_CTLA;
      else if (idx == IDX_CTLD) tgt = TGT_CTLD;
      else                      tgt = TGT_LOW;
    end else begin
      case (page)
        PAGE_0: tgt = TGT_PAGE0;
        PAGE_2: tgt = TGT_PAGE2;
        PAGE_1: begin
          if (idx == IDX_XPTR)      tgt = TGT_XPTR;
          else if (idx == IDX_XDAT) tgt = TGT_XDAT;
          else                      tgt = TGT_NONE;
        end
        default: tgt = TGT_NONE;
      endcase
    end
  end

  // R5: the second-level registers are reachable only through page 1
  always_comb begin
    if (page != PAGE_1) begin
      a_r5_ext_only_page1: assert (tgt != TGT_XPTR && tgt != TGT_XDAT);
    end
  end
endmodule

// File: rtl/rtc_win_store.sv
module rtc_win_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/rtc_bank_window.sv
module rtc_bank_window
  import rtc_win_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 7,
  parameter int XRAM_DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_port,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              ram_valid
);
  localparam int HALF = 1 << (IDX_W - 1);
  localparam int HW   = IDX_W - 1;
  localparam int XW   = $clog2(XRAM_DEPTH);

  // reset: asserted asynchronously, released synchronously
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // architectural state
  logic [IDX_W-1:0]  idx_q,  idx_d;
  logic [DATA_W-1:0] ctla_q, ctla_d;
  logic [DATA_W-2:0] ctld_q, ctld_d;
  logic [XW-1:0]     xptr_q, xptr_d;
  logic              seen_q, seen_d;

  // bus strobes
  logic data_rd, data_wr, ptr_wr;
  assign data_rd = host_sel && host_rd && host_port;
  assign data_wr = host_sel && host_wr && host_port && ram_valid;
  assign ptr_wr  = host_sel && host_wr && !host_port;

  tgt_e tgt;
  rtc_win_decode u_dec (
    .idx  (idx_q),
    .page (ctla_q[6:4]),
    .tgt  (tgt)
  );

  // storage
  logic [DATA_W-1:0] low_rdata, xram_rdata;
  logic [DATA_W-1:0] page_rdata [2];

  rtc_win_store #(.DEPTH(HALF), .DATA_W(DATA_W)) u_low (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (data_wr && tgt == TGT_LOW),
    .addr  (idx_q[HW-1:0]),
    .wdata (host_wdata),
    .rdata (low_rdata)
  );

  for (genvar g = 0; g < 2; g++) begin : g_page
    localparam tgt_e MY_TGT = (g == 0) ? TGT_PAGE0 : TGT_PAGE2;
    rtc_win_store #(.DEPTH(HALF), .DATA_W(DATA_W)) u_page (
      .clk   (clk),
      .rst_n (rst_int_n),
      .we    (data_wr && tgt == MY_TGT),
      .addr  (idx_q[HW-1:0]),
      .wdata (host_wdata),
      .rdata (page_rdata[g])
    );
  end

  rtc_win_store #(.DEPTH(XRAM_DEPTH), .DATA_W(DATA_W)) u_xram (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (data_wr && tgt == TGT_XDAT),
    .addr  (xptr_q),
    .wdata (host_wdata),
    .rdata (xram_rdata)
  );

  // next state
  always_comb begin
    idx_d  = idx_q;
    ctla_d = ctla_q;
    ctld_d = ctld_q;
    xptr_d = xptr_q;
    seen_d = seen_q;
    if (ptr_wr) idx_d = host_wdata[IDX_W-1:0];
    if (data_wr && tgt == TGT_CTLA && seen_q) ctla_d = host_wdata;
    if (data_wr && tgt == TGT_CTLD) ctld_d = host_wdata[DATA_W-2:0];
    if (data_wr && tgt == TGT_XPTR) xptr_d = host_wdata[XW-1:0];
    if (data_rd && tgt == TGT_CTLD) seen_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      idx_q  <= '0;
      ctla_q <= '0;
      ctld_q <= '0;
      xptr_q <= '0;
      seen_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      ctla_q <= ctla_d;
      ctld_q <= ctld_d;
      xptr_q <= xptr_d;
      seen_q <= seen_d;
    end
  end

  // read path
  logic [DATA_W-1:0] data_val;
  always_comb begin
    case (tgt)
      TGT_LOW:   data_val = low_rdata;
      TGT_CTLA:  data_val = ctla_q;
      TGT_CTLD:  data_val = {ram_valid, ctld_q};
      TGT_PAGE0: data_val = page_rdata[0];
      TGT_PAGE2: data_val = page_rdata[1];
      TGT_XPTR:  data_val = {{(DATA_W-XW){1'b0}}, xptr_q};
      TGT_XDAT:  data_val = xram_rdata;
      default:   data_val = '0;
    endcase
  end

  always_comb begin
    host_rdata = '0;
    if (host_sel && host_rd) begin
      host_rdata = host_port ? data_val : {{(DATA_W-IDX_W){1'b0}}, idx_q};
    end
  end

  // assertions
  a_r1_pointer_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(host_sel && host_wr && !host_port) |=> $stable(idx_q));

  a_r7_invalid_write_dropped: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_sel && host_wr && host_port && !ram_valid)
      |=> ($stable(ctla_q) && $stable(ctld_q) && $stable(xptr_q)));

  a_r8_ctla_locked: assert property (@(posedge clk) disable iff (!rst_int_n)
    !seen_q |=> $stable(ctla_q));

  a_r8_permission_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    seen_q |=> seen_q);

  a_r4_ptr_msb_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_sel && host_rd && host_port && tgt == TGT_XPTR) |-> !host_rdata[DATA_W-1]);

  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(host_sel && host_rd) |-> host_rdata == '0);
endmodule

// File: tb/rtc_bank_window_test.sv
module rtc_bank_window_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_sel = 1'b0, host_port = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       ram_valid = 1'b0;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;

  always #10 clk = ~clk;

  rtc_bank_window uut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_port(host_port),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ram_valid(ram_valid)
  );

  // behavioural reference: flat key space
  int m_mem [0:2047];
  int m_ptr, m_xptr;
  bit m_seen;

  function automatic int m_page();
    return (m_mem[10] >> 4) & 7;
  endfunction

  function automatic int m_key(int i);
    if (i < 64) return i;
    if (m_page() == 0) return 200 + i;
    if (m_page() == 2) return 400 + i;
    return -1;
  endfunction

  function automatic int m_read(bit port);
    int k;
    if (!port) return m_ptr;
    if (m_ptr == 13) return (int'(ram_valid) << 7) | (m_mem[13] & 127);
    if (m_ptr >= 64 && m_page() == 1) begin
      if (m_ptr == 'h50) return m_xptr;
      if (m_ptr == 'h53) return m_mem[1000 + m_xptr];
      return 0;
    end
    k = m_key(m_ptr);
    return (k < 0) ? 0 : m_mem[k];
  endfunction

  function automatic void m_write(bit port, int d);
    int k;
    if (!port) begin m_ptr = d & 127; return; end
    if (!ram_valid) return;
    if (m_ptr == 10 && !m_seen) return;
    if (m_ptr >= 64 && m_page() == 1) begin
      if (m_ptr == 'h50) m_xptr = d & 127;
      else if (m_ptr == 'h53) m_mem[1000 + m_xptr] = d;
      return;
    end
    k = m_key(m_ptr);
    if (k >= 0) m_mem[k] = d;
  endfunction

  task automatic check(int got, int exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic bus_rd(bit port, string tag);
    @(negedge clk);
    host_sel = 1; host_rd = 1; host_wr = 0; host_port = port;
    #5;
    check(int'(host_rdata), m_read(port), tag);
    @(posedge clk); #1;
    if (port && m_ptr == 13) m_seen = 1;
    host_sel = 0; host_rd = 0;
  endtask

  task automatic bus_wr(bit port, int d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_rd = 0; host_port = port; host_wdata = d[7:0];
    @(posedge clk); #1;
    m_write(port, d);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic put(int i, int d);
    bus_wr(0, i);
    bus_wr(1, d);
  endtask

  task automatic get(int i, string tag);
    bus_wr(0, i);
    bus_rd(1, tag);
  endtask

  // idle bus must read zero on every cycle (R9)
  always @(negedge clk) begin
    #5;
    if (live && !host_sel) check(int'(host_rdata), 0, "R9 idle read");
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lf;
    for (int i = 0; i < 2048; i++) m_mem[i] = 0;
    m_ptr = 0; m_xptr = 0; m_seen = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    live = 1;

    // reset state
    bus_rd(0, "R9 pointer after reset");
    get(10, "R9 ctla after reset");

    // ram_valid low: data writes dropped, pointer still works
    put(5, 'hAA);
    get(5, "R7 write dropped while invalid");
    bus_wr(0, 'hF3);
    bus_rd(0, "R1 pointer loads low 7 bits");

    ram_valid = 1;
    // CRA locked before 0Dh read
    put(10, 'h20);
    get(10, "R8 ctla locked before 0Dh read");
    get(13, "R6 0Dh shows valid bit");
    put(10, 'h8F);
    get(10, "R8 ctla writable after 0Dh read, R2 all bits");
    bus_rd(0, "R1 pointer held across data access");

    // CRD bit 7 follows input
    put(13, 'h55);
    get(13, "R6 0Dh stored bits with valid");
    ram_valid = 0;
    bus_rd(1, "R6 0Dh bit7 follows input");
    ram_valid = 1;

    // pages 0 and 2 separate, lower bytes shared
    put(10, 'h00);
    put('h45, 'h11);
    put(11, 'h5A);
    put(10, 'h20);
    get('h45, "R3 page2 store separate");
    put('h45, 'h22);
    get(11, "R2 0Bh shared across pages");
    put(10, 'h00);
    get('h45, "R3 page0 content kept");
    put(10, 'h20);
    get('h45, "R3 page2 content kept");

    // page 1 second-level access
    put(10, 'h10);
    get('h45, "R5 page1 unmapped reads zero");
    put('h45, 'h99);
    get('h45, "R5 page1 unmapped write ignored");
    put('h50, 'hFF);
    get('h50, "R4 ext pointer 7 bits");
    put('h53, 'h3C);
    get('h53, "R4 ext data write");
    bus_rd(1, "R4 ext data repeat read");
    get('h50, "R4 ext pointer no increment");
    put('h50, 0);
    put('h53, 'hC3);
    put('h50, 'h7F);
    get('h53, "R4 ext bytes distinct");

    // other page codes
    put(10, 'h50);
    get('h60, "R5 page5 reads zero");
    put('h60, 'h77);
    get('h60, "R5 page5 write ignored");

    // pseudo-random sweep
    lf = 'hACE1;
    for (int n = 0; n < 400; n++) begin
      int pg, ix, dv;
      lf = (lf >> 1) ^ ((lf & 1) ? 'hB400 : 0);
      pg = (lf & 3) == 3 ? 5 : (lf & 3);
      ix = (lf >> 2) & 127;
      if (ix == 10 || ix == 13) ix = 'h53;
      if ((lf & 12) == 8) ix = 'h50;
      dv = (lf >> 5) & 255;
      ram_valid = (n % 7) != 3;
      if (ram_valid) put(10, pg << 4);
      put(ix, dv);
      get(ix, "R2 R3 R4 sweep readback");
      get((ix ^ (lf >> 9)) & 127, "R5 R7 sweep other location");
    end
    ram_valid = 1;

    live = 0;
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule